// File: doc/BRIEF.md
# Direct-Mapped Cache with Four-Word Lines and Write Fill

This block sits between a 32-bit byte-addressed processor and main memory. It stores copies of memory in lines of four 32-bit words (16 bytes) and places every line at exactly one slot, chosen by address bits above the in-line word field. A read hit returns its word in the cycle it is presented. A write hit updates its word in the line and sends the same word to memory in that cycle, so memory always holds the latest data (write-through).

On any miss, read or write, the cache holds the processor in a stall. It asks memory for the whole aligned 16-byte block and stores the four returned words in order. Only then does it mark the line valid. The stalled access then completes as a hit. A write miss therefore never leaves a line that mixes words from two blocks under one tag. The processor keeps its request, address, direction and write data steady while the stall is high.

Top module: `blk4_cache`

## Requirements
- R1: After reset every line is invalid, so the first access to any address misses. No memory read is requested while the processor presents no request.
- R2: A read hit drives the addressed word on `cpu_rdata` with `cpu_stall` low in the same cycle. Bits 3:2 of the address select word 0 to 3 of the line.
- R3: On a miss, `mem_rd_req` rises in the next cycle with `mem_rd_addr` equal to the access address with bits 3:0 cleared. It stays high with a steady address until four beats flagged by `mem_rd_valid` have arrived. Those beats carry words 0, 1, 2 and 3 of the block, in that order.
- R4: A write miss first loads the whole block and only then merges the written word. The other three words of the line hold the values from memory.
- R5: `cpu_stall` stays high from the miss cycle until the fourth beat has been stored. The line turns valid only at that beat. The held access completes as a hit in the following cycle, so a miss with two idle cycles before the first beat takes 8 cycles in total.
- R6: A write hit updates the selected word and pulses `mem_wr_req` for exactly that cycle, with `mem_wr_addr` and `mem_wr_data` equal to the processor's address and data. No memory write is issued while the access is stalled.
- R7: After an access to byte address 16 misses and fills, accesses to byte addresses 24 and 20 hit without a stall.
- R8: The line index is address bits [IDX_W+3:4] and the tag is the bits above it. Two addresses with the same index and different tags evict each other, and each return costs a full fill.
- R9: Address bits 1:0 have no effect on which word is read or written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor access request |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data, valid on a read hit |
| cpu_stall | output | 1 | Access not finished, hold inputs |
| mem_rd_req | output | 1 | Block read request, held during fill |
| mem_rd_addr | output | ADDR_W | Aligned block address |
| mem_rd_valid | input | 1 | One fill beat is present |
| mem_rd_data | input | 32 | Fill beat data |
| mem_wr_req | output | 1 | Write-through strobe |
| mem_wr_addr | output | ADDR_W | Write-through address |
| mem_wr_data | output | 32 | Write-through data |

## Verification
The cache is driven with cold reads, reads of the other words in a freshly loaded block, write misses and write hits, reads of a conflicting block that shares an index, and addresses with nonzero byte offsets. Cold reads measure the exact stall length and the order of fill beats. Neighbour reads show that the whole block became resident. Write misses followed by reads of the same block show whether the fill happened before the merge or the tag was overwritten blindly. Conflicting blocks separate index bits from tag bits, and byte offsets show that word selection ignores the lowest two bits.

// File: rtl/blk4_cache.sv
module blk4_cache #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [31:0]       cpu_wdata,
  output logic [31:0]       cpu_rdata,
  output logic              cpu_stall,
  output logic              mem_rd_req,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rd_valid,
  input  logic [31:0]       mem_rd_data,
  output logic              mem_wr_req,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [31:0]       mem_wr_data
);
  localparam int LINES = 1 << IDX_W;
  localparam int TAG_W = ADDR_W - IDX_W - 4;
  localparam int BLK_W = ADDR_W - 4;

  logic [31:0]      words [0:LINES*4-1];
  logic [TAG_W-1:0] tags  [0:LINES-1];
  logic [LINES-1:0] vld;
  logic             filling;
  logic [1:0]       beat;
  logic [BLK_W-1:0] fill_blk;

  wire [IDX_W-1:0] idx      = cpu_addr[IDX_W+3:4];
  wire [TAG_W-1:0] tag      = cpu_addr[ADDR_W-1:IDX_W+4];
  wire [1:0]       wsel     = cpu_addr[3:2];
  wire [IDX_W-1:0] fill_idx = fill_blk[IDX_W-1:0];
  wire             hit      = cpu_req && !filling && vld[idx] && (tags[idx] == tag);
  wire             last     = filling && mem_rd_valid && (beat == 2'd3);

  assign cpu_stall   = cpu_req && !hit;
  assign cpu_rdata   = words[{idx, wsel}];
  assign mem_rd_req  = filling;
  assign mem_rd_addr = {fill_blk, 4'b0000};
  assign mem_wr_req  = hit && cpu_we;
  assign mem_wr_addr = cpu_addr;
  assign mem_wr_data = cpu_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld      <= '0;
      filling  <= 1'b0;
      beat     <= 2'd0;
      fill_blk <= '0;
    end else if (filling) begin
      if (mem_rd_valid) beat <= beat + 2'd1;
      if (last) begin
        filling       <= 1'b0;
        vld[fill_idx] <= 1'b1;
      end
    end else if (cpu_req && !hit) begin
      filling  <= 1'b1;
      beat     <= 2'd0;
      fill_blk <= cpu_addr[ADDR_W-1:4];
      vld[idx] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (filling && mem_rd_valid) begin
      words[{fill_idx, beat}] <= mem_rd_data;
      if (beat == 2'd3) tags[fill_idx] <= fill_blk[BLK_W-1:IDX_W];
    end else if (mem_wr_req) begin
      words[{idx, wsel}] <= cpu_wdata;
    end
  end
endmodule

// File: rtl/blk4_cache_chk.sv
module blk4_cache_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_req,
  input logic              cpu_we,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              cpu_stall,
  input logic              mem_rd_req,
  input logic [ADDR_W-1:0] mem_rd_addr,
  input logic              mem_wr_req,
  input logic [ADDR_W-1:0] mem_wr_addr
);
  AST_RD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |-> (mem_rd_addr[3:0] == 4'd0)); // R3
  AST_RD_ADDR_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req && $past(mem_rd_req)) |-> $stable(mem_rd_addr)); // R3
  AST_FILL_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req && cpu_req) |-> cpu_stall); // R5
  AST_WR_NOT_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_req |-> !cpu_stall); // R6
  AST_WR_FROM_CPU: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_req |-> (cpu_req && cpu_we && mem_wr_addr == cpu_addr)); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_req && !mem_rd_req) |=> !mem_rd_req); // R1
endmodule

bind blk4_cache blk4_cache_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
  .cpu_addr(cpu_addr), .cpu_stall(cpu_stall), .mem_rd_req(mem_rd_req),
  .mem_rd_addr(mem_rd_addr), .mem_wr_req(mem_wr_req), .mem_wr_addr(mem_wr_addr)
);

// File: tb/sim_blk4_cache.sv
`timescale 1ns/1ps
module sim_blk4_cache;
  logic clk = 0, rst_n = 0;
  logic cpu_req = 0, cpu_we = 0;
  logic [31:0] cpu_addr = 0, cpu_wdata = 0;
  logic [31:0] cpu_rdata, mem_rd_addr, mem_wr_addr, mem_wr_data;
  logic cpu_stall, mem_rd_req, mem_wr_req;
  logic mem_rd_valid = 0;
  logic [31:0] mem_rd_data = 0;

  always #2 clk = ~clk;

  blk4_cache #(.ADDR_W(32), .IDX_W(4)) u0 (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .cpu_stall(cpu_stall), .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
    .mem_wr_req(mem_wr_req), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data));

  int checks = 0, fails = 0;
  logic [31:0] mainmem [0:1023];
  logic [31:0] mdata [0:63];
  int mtag [0:15];
  bit mvalid [0:15];
  bit mfill = 0;
  int fcyc = 0, fblk = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] init_word(input int i);
    return 32'hC0DE0000 + i * 7;
  endfunction

  task automatic step(input bit req, input bit we, input logic [31:0] addr, input logic [31:0] wd,
                      output bit stalled, output logic [31:0] rd);
    int idx, tg, ws, fidx;
    bit hit;
    @(negedge clk);
    cpu_req = req; cpu_we = we; cpu_addr = addr; cpu_wdata = wd;
    mem_rd_valid = mfill && fcyc >= 2;
    mem_rd_data = (mfill && fcyc >= 2) ? mainmem[fblk*4 + fcyc - 2] : 32'h0;
    #1;
    idx = (addr >> 4) & 15; tg = addr >> 8; ws = (addr >> 2) & 3;
    fidx = fblk & 15;
    hit = req && !mfill && mvalid[idx] && mtag[idx] == tg;
    chk(cpu_stall == (req && !hit), "R5 stall", {31'd0, cpu_stall}, {31'd0, req && !hit});
    chk(mem_rd_req == mfill, "R3 rd_req", {31'd0, mem_rd_req}, {31'd0, mfill});
    if (mfill) chk(mem_rd_addr == fblk << 4, "R3 rd_addr", mem_rd_addr, fblk << 4);
    chk(mem_wr_req == (hit && we), "R6 wr_req", {31'd0, mem_wr_req}, {31'd0, hit && we});
    if (hit && we) begin
      chk(mem_wr_addr == addr, "R6 wr_addr", mem_wr_addr, addr);
      chk(mem_wr_data == wd, "R6 wr_data", mem_wr_data, wd);
    end
    if (hit && !we) chk(cpu_rdata == mdata[idx*4 + ws], "R2 rdata", cpu_rdata, mdata[idx*4 + ws]);
    stalled = cpu_stall; rd = cpu_rdata;
    if (mfill) begin
      if (fcyc >= 2) mdata[fidx*4 + fcyc - 2] = mainmem[fblk*4 + fcyc - 2];
      if (fcyc == 5) begin
        mvalid[fidx] = 1; mtag[fidx] = fblk >> 4; mfill = 0;
      end else fcyc++;
    end else if (req) begin
      if (hit) begin
        if (we) begin
          mdata[idx*4 + ws] = wd;
          mainmem[(addr >> 2) & 1023] = wd;
        end
      end else begin
        mfill = 1; fcyc = 0; fblk = addr >> 4; mvalid[idx] = 0;
      end
    end
  endtask

  task automatic access(input bit we, input logic [31:0] addr, input logic [31:0] wd,
                        output int n, output logic [31:0] rd);
    bit st;
    n = 0;
    do begin
      step(1, we, addr, wd, st, rd);
      n++;
    end while (st && n < 50);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #600000;
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int n;
    bit st;
    logic [31:0] rd, a;
    for (int i = 0; i < 1024; i++) mainmem[i] = init_word(i);
    for (int i = 0; i < 16; i++) begin mvalid[i] = 0; mtag[i] = 0; end
    for (int i = 0; i < 64; i++) mdata[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: idle cycles after reset, no memory activity
    for (int i = 0; i < 3; i++) step(0, 0, 32'h0, 32'h0, st, rd);
    chk(!mem_rd_req && !cpu_stall, "R1 idle", {30'd0, mem_rd_req, cpu_stall}, 32'd0);
    // R1 R5: cold read misses, 8 cycles total
    access(0, 32'h10, 0, n, rd);
    chk(n == 8, "R5 miss length", n, 8);
    chk(rd == init_word(4), "R3 word0", rd, init_word(4));
    // R7: neighbours in same block hit
    access(0, 32'h18, 0, n, rd);
    chk(n == 1, "R7 addr24 hit", n, 1);
    chk(rd == init_word(6), "R7 addr24 data", rd, init_word(6));
    access(0, 32'h14, 0, n, rd);
    chk(n == 1, "R7 addr20 hit", n, 1);
    chk(rd == init_word(5), "R3 beat order", rd, init_word(5));
    access(0, 32'h1C, 0, n, rd);
    chk(rd == init_word(7), "R3 word3", rd, init_word(7));
    // R9: byte offset ignored
    access(0, 32'h1B, 0, n, rd);
    chk(n == 1 && rd == init_word(6), "R9 byte offset read", rd, init_word(6));
    // R4: write miss fills, then merges
    access(1, 32'h204, 32'hDEAD0001, n, rd);
    chk(n == 8, "R4 write miss fills", n, 8);
    access(0, 32'h200, 0, n, rd);
    chk(n == 1 && rd == init_word(128), "R4 neighbour from memory", rd, init_word(128));
    access(0, 32'h204, 0, n, rd);
    chk(rd == 32'hDEAD0001, "R4 merged word", rd, 32'hDEAD0001);
    access(0, 32'h20C, 0, n, rd);
    chk(rd == init_word(131), "R4 neighbour word3", rd, init_word(131));
    // R6: write hit with byte offset (R9)
    access(1, 32'h20A, 32'h12345678, n, rd);
    chk(n == 1, "R6 write hit no stall", n, 1);
    chk(mainmem[130] == 32'h12345678, "R6 memory updated", mainmem[130], 32'h12345678);
    access(0, 32'h208, 0, n, rd);
    chk(rd == 32'h12345678, "R9 write offset ignored", rd, 32'h12345678);
    // R8: conflicting blocks evict each other
    access(0, 32'h110, 0, n, rd);
    chk(n == 8 && rd == init_word(68), "R8 conflict miss", rd, init_word(68));
    access(0, 32'h10, 0, n, rd);
    chk(n == 8, "R8 evicted line refetched", n, 8);
    access(0, 32'h20, 0, n, rd);
    chk(n == 8, "R8 distinct index miss", n, 8);
    access(0, 32'h14, 0, n, rd);
    chk(n == 1, "R8 other index kept", n, 1);
    // mixed traffic
    for (int i = 0; i < 200; i++) begin
      a = ((i * 37) % 1024) << 2;
      access(i % 3 == 0, a, 32'hA000_0000 + i, n, rd);
      if (i % 5 == 0) step(0, 0, 32'h0, 32'h0, st, rd);
    end
    step(0, 0, 32'h0, 32'h0, st, rd);
    finish_run();
  end
endmodule